// File: doc/BRIEF.md
# Timer Interrupt Status and Pin Routing

This block gathers end-of-cycle events from two timers and from any number of further event sources into a status register. Each event has its own enable bit and its own routing bit. An enabled event that software has not yet acknowledged drives one of two pins. The first is the primary interrupt pin. The second is a multi-function pin, which can instead carry the raw timer 0 output or the oscillator. Software acknowledges events by writing ones to the status register. A summary bit in that register shows whether any enabled event is waiting at a pin.

The block also holds the polarity and drive-type settings for three pins: the primary interrupt pin, the multi-function pin and the timer 1 output. A standby input forces all three drive-type outputs to open-drain. While standby is high, interrupt assertion on the pins is blocked unless a standby-interrupt bit is set. The event inputs and the register port are plain single-cycle control signals, so there is no handshake and no back-pressure. An event pulse is captured in the cycle it is high. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`.

Register map (byte wide, `addr` 3 bits): 0 = status, 1 = enable, 2 = routing, 3 = pin configuration, 4 = standby configuration. Any other address reads zero.

Top module: `tirq_route_top`

## Requirements
- R1: After reset, every register reads 0. `irq_o` and `mfp_o` are low, `t1_o` follows `t1_out`, and all three drive-type outputs are low.
- R2: A high `evt[i]` at a clock edge sets status bit i+1 (address 0), whether or not the event is enabled. The bit stays set until it is cleared.
- R3: A write to address 0 clears each status bit i+1 whose data bit is 1. Data bits that are 0, and data bit 0, have no effect.
- R4: If `evt[i]` is high in the same cycle as a write that clears bit i+1, the bit is set after that edge.
- R5: Status bit 0 reads 1 exactly when some status bit i+1 is set and enable bit i (address 1) is 1.
- R6: `irq_o` equals P XOR pin-config bit 2. P is 1 when some enabled, set status bit has routing bit i (address 2) equal to 0.
- R7: With pin-config bits [1:0] = 00, `mfp_o` equals M XOR pin-config bit 3. M is 1 when some enabled, set status bit has routing bit 1.
- R8: With pin-config bits [1:0] = 01, `mfp_o` equals `t0_out` XOR bit 3. With bit 1 = 1, `mfp_o` equals `osc_i` unmodified.
- R9: `t1_o` equals `t1_out` XOR pin-config bit 4.
- R10: `irq_od_o`, `mfp_od_o` and `t1_od_o` equal pin-config bits 5, 6 and 7, each ORed with `standby`.
- R11: While `standby` is high and standby-config bit 0 is 0, P and M are forced to 0. Status capture is not affected.
- R12: Addresses 1 to 4 read back the last value written, limited to their implemented bits: enable and routing use bits [3:0], pin config uses bits [7:0], standby config uses bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 4 | Event pulses; bit 0 timer 0, bit 1 timer 1, others generic |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| standby | input | 1 | Standby condition |
| t0_out | input | 1 | Timer 0 waveform |
| t1_out | input | 1 | Timer 1 waveform |
| osc_i | input | 1 | Oscillator signal |
| irq_o | output | 1 | Primary interrupt pin level |
| mfp_o | output | 1 | Multi-function pin level |
| t1_o | output | 1 | Timer 1 pin level |
| irq_od_o | output | 1 | Primary pin open-drain select |
| mfp_od_o | output | 1 | Multi-function pin open-drain select |
| t1_od_o | output | 1 | Timer 1 pin open-drain select |

## Verification
Two functions can act on one status bit in the same cycle: event capture and the write-one clear. The bench provokes this with a directed write to address 0 that clears a bit in the very cycle its event is pulsed. It then repeats the collision with random event vectors and random clear masks, together with random enable, routing and standby settings. A behavioural reference model is compared with status, summary and pin levels on every cycle, and an event that is lost in a collision shows up as a status mismatch.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int unsigned ADR_STAT  = 0;
  localparam int unsigned ADR_EN    = 1;
  localparam int unsigned ADR_ROUTE = 2;
  localparam int unsigned ADR_OCFG  = 3;
  localparam int unsigned ADR_SCFG  = 4;

  typedef enum logic [1:0] {
    MFP_IRQ2 = 2'b00,
    MFP_T0   = 2'b01,
    MFP_OSCA = 2'b10,
    MFP_OSCB = 2'b11
  } mfp_sel_e;

  typedef struct packed {
    logic     t1_od;
    logic     mfp_od;
    logic     irq_od;
    logic     t1_pol;
    logic     mfp_pol;
    logic     irq_pol;
    mfp_sel_e sel;
  } ocfg_t;
endpackage

// File: rtl/tirq_cfg_regs.sv
module tirq_cfg_regs
  import tirq_pkg::*;
#(
  parameter int N_EVT = 4,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [N_EVT-1:0] en,
  output logic [N_EVT-1:0] route,
  output ocfg_t            ocfg,
  output logic             stby_irq_en
);
  localparam int OW = $bits(ocfg_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en          <= '0;
      route       <= '0;
      ocfg        <= '0;
      stby_irq_en <= 1'b0;
    end else if (wr_en) begin
      if (addr == AW'(ADR_EN))    en          <= wdata[N_EVT-1:0];
      if (addr == AW'(ADR_ROUTE)) route       <= wdata[N_EVT-1:0];
      if (addr == AW'(ADR_OCFG))  ocfg        <= ocfg_t'(wdata[OW-1:0]);
      if (addr == AW'(ADR_SCFG))  stby_irq_en <= wdata[0];
    end
  end
endmodule

// File: rtl/tirq_status.sv
module tirq_status #(
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EVT-1:0] clr,
  output logic [N_EVT-1:0] stat
);
  // New events override a same-cycle clear of the same bit.
  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat[i] <= 1'b0;
      else if (evt[i]) stat[i] <= 1'b1;
      else if (clr[i]) stat[i] <= 1'b0;
    end
  end

  // R4: an event is never lost, even under a clear
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));

  // R3: a clear without an event empties the bit
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~evt)) |=> ((stat & $past(clr & ~evt)) == '0));

  // R2: a set bit drops only under a clear
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat) & ~$past(clr) & ~stat) == '0));
endmodule

// File: rtl/tirq_pin_mux.sv
module tirq_pin_mux
  import tirq_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input  logic [N_EVT-1:0] stat,
  input  logic [N_EVT-1:0] en,
  input  logic [N_EVT-1:0] route,
  input  ocfg_t            ocfg,
  input  logic             stby_irq_en,
  input  logic             standby,
  input  logic             t0_out,
  input  logic             t1_out,
  input  logic             osc_i,
  output logic             pend,
  output logic             irq_o,
  output logic             mfp_o,
  output logic             t1_o,
  output logic             irq_od_o,
  output logic             mfp_od_o,
  output logic             t1_od_o
);
  logic [N_EVT-1:0] live, to_irq, to_mfp;
  logic             gate, irq_act, mfp_act;

  for (genvar i = 0; i < N_EVT; i++) begin : g_route
    assign live[i]   = stat[i] & en[i];
    assign to_irq[i] = live[i] & ~route[i];
    assign to_mfp[i] = live[i] &  route[i];
  end

  assign pend    = |live;
  assign gate    = ~standby | stby_irq_en;
  assign irq_act = (|to_irq) & gate;
  assign mfp_act = (|to_mfp) & gate;

  always_comb begin
    unique case (ocfg.sel)
      MFP_IRQ2:           mfp_o = mfp_act ^ ocfg.mfp_pol;
      MFP_T0:             mfp_o = t0_out  ^ ocfg.mfp_pol;
      MFP_OSCA, MFP_OSCB: mfp_o = osc_i;
      default:            mfp_o = 1'b0;
    endcase
  end

  assign irq_o    = irq_act ^ ocfg.irq_pol;
  assign t1_o     = t1_out  ^ ocfg.t1_pol;
  assign irq_od_o = ocfg.irq_od | standby;
  assign mfp_od_o = ocfg.mfp_od | standby;
  assign t1_od_o  = ocfg.t1_od  | standby;
endmodule

// File: rtl/tirq_route_top.sv
module tirq_route_top
  import tirq_pkg::*;
#(
  parameter int N_EVT = 4,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_data,
  input  logic             standby,
  input  logic             t0_out,
  input  logic             t1_out,
  input  logic             osc_i,
  output logic             irq_o,
  output logic             mfp_o,
  output logic             t1_o,
  output logic             irq_od_o,
  output logic             mfp_od_o,
  output logic             t1_od_o
);
  localparam int OW    = $bits(ocfg_t);
  localparam int SPAD  = DW - N_EVT - 1;
  localparam int EPAD  = DW - N_EVT;
  localparam int OPAD  = DW - OW;

  logic [N_EVT-1:0] stat, en, route, clr;
  ocfg_t            ocfg;
  logic             stby_irq_en, pend;

  assign clr = (wr_en && addr == AW'(ADR_STAT)) ? wdata[N_EVT:1] : '0;

  tirq_cfg_regs #(.N_EVT(N_EVT), .DW(DW), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .en(en), .route(route), .ocfg(ocfg), .stby_irq_en(stby_irq_en)
  );

  tirq_status #(.N_EVT(N_EVT)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .stat(stat)
  );

  tirq_pin_mux #(.N_EVT(N_EVT)) u_pins (
    .stat(stat), .en(en), .route(route), .ocfg(ocfg),
    .stby_irq_en(stby_irq_en), .standby(standby),
    .t0_out(t0_out), .t1_out(t1_out), .osc_i(osc_i),
    .pend(pend), .irq_o(irq_o), .mfp_o(mfp_o), .t1_o(t1_o),
    .irq_od_o(irq_od_o), .mfp_od_o(mfp_od_o), .t1_od_o(t1_od_o)
  );

  always_comb begin
    rd_data = '0;
    if      (addr == AW'(ADR_STAT))  rd_data = {{SPAD{1'b0}}, stat, pend};
    else if (addr == AW'(ADR_EN))    rd_data = {{EPAD{1'b0}}, en};
    else if (addr == AW'(ADR_ROUTE)) rd_data = {{EPAD{1'b0}}, route};
    else if (addr == AW'(ADR_OCFG))  rd_data = {{OPAD{1'b0}}, ocfg};
    else if (addr == AW'(ADR_SCFG))  rd_data = {{(DW-1){1'b0}}, stby_irq_en};
  end

  // R11: standby without the standby-interrupt bit keeps the primary pin idle
  a_r11_standby_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !stby_irq_en) |-> (irq_o == ocfg.irq_pol));

  // R10: standby forces every pin to open-drain
  a_r10_standby_od: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (irq_od_o && mfp_od_o && t1_od_o));

  // R5: summary follows a status bit captured while enabled
  a_r5_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & en) && !wr_en) |=> rd_data[0] || addr != AW'(ADR_STAT));
endmodule

// File: tb/sim_tirq_route_top.sv
module sim_tirq_route_top;
  localparam int N = 4;
  localparam int DW = 8;
  localparam int AW = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] evt = '0;
  logic wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic standby = 0, t0_out = 0, t1_out = 0, osc_i = 0;
  logic irq_o, mfp_o, t1_o, irq_od_o, mfp_od_o, t1_od_o;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  tirq_route_top u0 (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .standby(standby), .t0_out(t0_out),
    .t1_out(t1_out), .osc_i(osc_i), .irq_o(irq_o), .mfp_o(mfp_o),
    .t1_o(t1_o), .irq_od_o(irq_od_o), .mfp_od_o(mfp_od_o), .t1_od_o(t1_od_o)
  );

  // Behavioural reference state
  bit [N-1:0] m_stat, m_en, m_route;
  bit [7:0]   m_ocfg;
  bit         m_sby;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_route = 0; m_ocfg = 0; m_sby = 0;
    end else begin
      bit [N-1:0] nxt;
      nxt = m_stat;
      if (wr_en) begin
        case (int'(addr))
          0: nxt = nxt & ~wdata[N:1];
          1: m_en = wdata[N-1:0];
          2: m_route = wdata[N-1:0];
          3: m_ocfg = wdata;
          4: m_sby = wdata[0];
          default: ;
        endcase
      end
      m_stat = nxt | evt;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit pp, pm, gate;
    int er, em;
    cycles++;
    pp = 0; pm = 0;
    for (int i = 0; i < N; i++) begin
      if (m_stat[i] && m_en[i] && !m_route[i]) pp = 1;
      if (m_stat[i] && m_en[i] &&  m_route[i]) pm = 1;
    end
    gate = !standby || m_sby;
    case (int'(addr))
      0: er = {m_stat, |(m_stat & m_en)};
      1: er = m_en;
      2: er = m_route;
      3: er = m_ocfg;
      4: er = m_sby;
      default: er = 0;
    endcase
    if (m_ocfg[1]) em = osc_i;
    else if (m_ocfg[0]) em = t0_out ^ m_ocfg[3];
    else em = (pm & gate) ^ m_ocfg[3];
    chk((addr == 0) ? ((tag == "R1") ? "R1" : (tag == "R2") ? "R2/R5" : tag) : (tag == "R1" ? "R1" : "R12"),
        "rd_data", rd_data, er);
    chk(standby ? "R11" : "R6", "irq_o", irq_o, (pp & gate) ^ m_ocfg[2]);
    chk(m_ocfg[1:0] == 0 ? (standby ? "R11" : "R7") : "R8", "mfp_o", mfp_o, em);
    chk("R9", "t1_o", t1_o, t1_out ^ m_ocfg[4]);
    chk("R10", "od", {t1_od_o, mfp_od_o, irq_od_o}, m_ocfg[7:5] | {3{standby}});
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic wr(int a, int d);
    wr_en = 1; addr = AW'(a); wdata = DW'(d); tick(); wr_en = 0;
  endtask

  initial begin
    #1;
    repeat (3) tick();
    rst_n = 1; tick();
    tag = "R12";
    wr(1, 8'h0F); wr(2, 8'h0A); addr = 1; tick(); addr = 2; tick();
    wr(4, 8'h01); addr = 4; tick(); wr(4, 0);
    tag = "R2"; addr = 0;
    evt = 4'b0001; tick(); evt = 0; tick();
    evt = 4'b0110; tick(); evt = 0; tick(); tick();
    tag = "R3";
    wr(0, 8'b0000_0101); addr = 0; tick();
    wr(0, 8'b0001_1111); addr = 0; tick();
    tag = "R4";
    evt = 4'b0001; tick(); evt = 0;
    evt = 4'b0001; wr(0, 8'b0000_0010); evt = 0; addr = 0; tick();
    evt = 4'b1000; wr(0, 8'b0001_1110); evt = 0; addr = 0; tick();
    tag = "R5";
    wr(1, 8'h00); addr = 0; tick(); wr(1, 8'h08); addr = 0; tick();
    tag = "R2";
    for (int s = 0; s < 4; s++) begin
      wr(3, (s * 8'h1C) | s);
      for (int k = 0; k < 4; k++) begin
        t0_out = k[0]; osc_i = k[1]; t1_out = ~k[0]; tick();
      end
    end
    wr(3, 0); evt = 4'b0011; tick(); evt = 0;
    tag = "R11";
    standby = 1; addr = 0; tick(); evt = 4'b0100; tick(); evt = 0; tick();
    wr(4, 1); tick(); wr(4, 0); standby = 0; tick();
    tag = "R2";
    for (int n = 0; n < 400; n++) begin
      evt = N'($urandom);
      standby = ($urandom % 8) == 0;
      t0_out = $urandom; t1_out = $urandom; osc_i = $urandom;
      if ($urandom % 3 == 0) begin
        wr_en = 1; addr = AW'($urandom % 6); wdata = DW'($urandom);
      end else begin
        wr_en = 0; addr = AW'($urandom % 6);
      end
      tick();
    end
    wr_en = 0; evt = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule